// File: doc/BRIEF.md
# Byte-Wide Boot Image Copier

This block runs once the processor leaves reset. On a start pulse it walks a boot image held in an 8-bit external memory that is reached through data address space. It pairs consecutive bytes into 16-bit words and stores each word through a 16-bit RAM write port. The RAM behind that port may be internal or external.

The image opens with a header. The header gives the destination address of the first word and the number of words that follow it. Every 16-bit field sits in memory high byte first. When the last word has been stored, the block raises `done` and drives the destination address on `jumpAddr`. The processor then begins execution at that address, which is the start of the loaded code. The copier does not check the image for errors and does not execute code.

Top module: `byte_boot_loader`

## Requirements
- R1: Out of reset, `done`, `extRdEn` and `ramWe` are low.
- R2: A start pulse sampled while idle or done begins the reads at address `IMG_BASE`. Each later byte is read from the next address up.
- R3: Each byte read holds `extAddr` for exactly two clocks with `extRdEn` high. The byte is sampled at the clock edge that ends the second clock. The next byte's read follows directly.
- R4: Image bytes 0 and 1 form the destination address, and bytes 2 and 3 form the word count. In each pair the byte at the lower address is bits 15:8.
- R5: Each data word is the byte at the lower address in bits 15:8 and the following byte in bits 7:0.
- R6: `ramWe` pulses for one clock, in the clock after the low byte of a word is sampled. The first write goes to the destination address. Each later write goes to the previous address plus one, wrapping at 16 bits.
- R7: When the word count is zero, no RAM write occurs. `done` rises in the clock after the count's low byte is sampled, which is 8 edges after the start edge.
- R8: For N > 0 words, `done` rises 9 + 4N edges after the start edge. It stays high with `jumpAddr` equal to the destination address, and no reads or writes take place, until the next start.
- R9: A start pulse during a copy is ignored. The writes and the completion time stay the same.
- R10: A start pulse while `done` is high clears `done` and runs a fresh copy of the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a copy when idle or done |
| extAddr | output | EXT_AW | Byte address into the external boot memory |
| extRdEn | output | 1 | Read strobe to the external memory |
| extData | input | 8 | Byte returned by the external memory |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | 16 | RAM word address |
| ramData | output | 16 | RAM word data |
| done | output | 1 | Copy finished |
| jumpAddr | output | 16 | Program start address handed to the processor |

## Verification
Take the start edge as edge 0. Byte k is sampled at edge 2k+2, and each word's write strobe is visible in the clock after its low byte is sampled. `done` is due at edge 9+4N, or at edge 8 when the count is zero. The bench counts falling edges from the start edge and checks `done` against 10+4N (or 9) samples. A scoreboard compares every write pulse against the queued (address, data) pairs as it appears. A monitor checks that each read address is held for exactly two sampled clocks and steps up by one.

// File: rtl/bbl_pkg.sv
package bbl_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_FLUSH,
    ST_DONE
  } seq_state_t;

  // Strobes from control to datapath, one clock each
  typedef struct packed {
    logic clr;    // restart image read pointer
    logic capHi;  // sample high byte of a pair
    logic capLo;  // sample low byte of a pair
    logic ldDst;  // low byte of destination field
    logic ldCnt;  // low byte of count field
    logic wr;     // low byte of a data word
  } strobe_t;
endpackage

// File: rtl/bbl_ctrl.sv
module bbl_ctrl
  import bbl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cntInZero,
  input  logic    lastWord,
  output strobe_t stb,
  output logic    rdEn,
  output logic    doneOut
);
  seq_state_t state;
  logic phase;
  logic lowNext;
  logic [1:0] hdrIdx;
  logic capture;
  logic idleLike;

  assign rdEn     = (state == ST_HDR) || (state == ST_DATA);
  assign capture  = rdEn && phase;
  assign idleLike = (state == ST_IDLE) || (state == ST_DONE);
  assign doneOut  = (state == ST_DONE);

  always_comb begin
    stb       = '0;
    stb.clr   = idleLike && start;
    stb.capHi = capture && !lowNext;
    stb.capLo = capture && lowNext;
    stb.ldDst = capture && lowNext && (state == ST_HDR) && (hdrIdx == 2'd1);
    stb.ldCnt = capture && lowNext && (state == ST_HDR) && (hdrIdx == 2'd3);
    stb.wr    = capture && lowNext && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      lowNext <= 1'b0;
      hdrIdx  <= 2'd0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_HDR;
            phase   <= 1'b0;
            lowNext <= 1'b0;
            hdrIdx  <= 2'd0;
          end
        end
        ST_HDR: begin
          phase <= !phase;
          if (capture) begin
            lowNext <= !lowNext;
            hdrIdx  <= hdrIdx + 2'd1;
            if (hdrIdx == 2'd3)
              state <= cntInZero ? ST_DONE : ST_DATA;
          end
        end
        ST_DATA: begin
          phase <= !phase;
          if (capture) begin
            lowNext <= !lowNext;
            if (lowNext && lastWord)
              state <= ST_FLUSH;
          end
        end
        ST_FLUSH: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bbl_dpath.sv
module bbl_dpath
  import bbl_pkg::*;
#(
  parameter int EXT_AW = 16,
  parameter logic [EXT_AW-1:0] IMG_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] extData,
  output logic [EXT_AW-1:0] extAddr,
  output logic              cntInZero,
  output logic              lastWord,
  output logic              ramWe,
  output logic [WORD_W-1:0] ramAddr,
  output logic [WORD_W-1:0] ramData,
  output logic [WORD_W-1:0] jumpAddr
);
  logic [EXT_AW-1:0] rdPtr;
  logic [BYTE_W-1:0] hiByte;
  logic [WORD_W-1:0] dst, ptr, remain, wordReg, joined;
  logic wrPend;

  assign joined    = {hiByte, extData};
  assign cntInZero = (joined == '0);
  assign lastWord  = (remain == WORD_W'(1));
  assign extAddr   = rdPtr;
  assign ramWe     = wrPend;
  assign ramAddr   = ptr;
  assign ramData   = wordReg;
  assign jumpAddr  = dst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= IMG_BASE;
      hiByte  <= '0;
      dst     <= '0;
      ptr     <= '0;
      remain  <= '0;
      wordReg <= '0;
      wrPend  <= 1'b0;
    end else begin
      if (stb.clr) rdPtr <= IMG_BASE;
      else if (stb.capHi || stb.capLo) rdPtr <= rdPtr + EXT_AW'(1);
      if (stb.capHi) hiByte <= extData;
      if (stb.ldDst) dst <= joined;
      if (stb.ldCnt) remain <= joined;
      else if (stb.wr) remain <= remain - WORD_W'(1);
      if (stb.wr) wordReg <= joined;
      wrPend <= stb.wr;
      if (stb.ldDst) ptr <= joined;
      else if (wrPend) ptr <= ptr + WORD_W'(1);
    end
  end
endmodule

// File: rtl/byte_boot_loader.sv
module byte_boot_loader
  import bbl_pkg::*;
#(
  parameter int EXT_AW = 16,
  parameter logic [EXT_AW-1:0] IMG_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [EXT_AW-1:0] extAddr,
  output logic              extRdEn,
  input  logic [7:0]        extData,
  output logic              ramWe,
  output logic [15:0]       ramAddr,
  output logic [15:0]       ramData,
  output logic              done,
  output logic [15:0]       jumpAddr
);
  strobe_t stb;
  logic cntInZero, lastWord;

  bbl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cntInZero(cntInZero), .lastWord(lastWord),
    .stb(stb), .rdEn(extRdEn), .doneOut(done)
  );

  bbl_dpath #(.EXT_AW(EXT_AW), .IMG_BASE(IMG_BASE)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .extData(extData),
    .extAddr(extAddr), .cntInZero(cntInZero), .lastWord(lastWord),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .jumpAddr(jumpAddr)
  );
endmodule

// File: rtl/bbl_checker.sv
module bbl_checker #(
  parameter int EXT_AW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [EXT_AW-1:0] extAddr,
  input logic              extRdEn,
  input logic              ramWe,
  input logic [15:0]       ramAddr,
  input logic              done,
  input logic [15:0]       jumpAddr
);
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!extRdEn && !ramWe)); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (extRdEn && $past(extRdEn) && extAddr != $past(extAddr)) |=> (extAddr == $past(extAddr))); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (extRdEn && $past(extRdEn) && extAddr != $past(extAddr)) |-> (extAddr == EXT_AW'($past(extAddr) + 1'b1))); // R2

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe); // R6

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> (ramAddr == 16'($past(ramAddr) + 1'b1))); // R6

  AST_JUMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> $stable(jumpAddr)); // R8
endmodule

bind byte_boot_loader bbl_checker #(.EXT_AW(EXT_AW)) u_chk (
  .clk(clk), .rstN(rstN), .extAddr(extAddr), .extRdEn(extRdEn),
  .ramWe(ramWe), .ramAddr(ramAddr), .done(done), .jumpAddr(jumpAddr)
);

// File: tb/byte_boot_loader_tb.sv
module byte_boot_loader_tb;
  localparam int EXT_AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [EXT_AW-1:0] extAddr;
  logic extRdEn;
  logic [7:0] extData;
  logic ramWe;
  logic [15:0] ramAddr, ramData, jumpAddr;
  logic done;

  logic [7:0] mem [0:255];
  int checks = 0;
  int errors = 0;

  typedef struct packed { logic [15:0] a; logic [15:0] d; } wr_t;
  wr_t expQ[$];

  always #10 clk = ~clk;

  assign extData = mem[extAddr[7:0]];

  byte_boot_loader #(.EXT_AW(EXT_AW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .extAddr(extAddr),
    .extRdEn(extRdEn), .extData(extData), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .done(done), .jumpAddr(jumpAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for writes, and read-address run checker (R2, R3)
  bit inRun = 0;
  logic [EXT_AW-1:0] runAddr;
  int runLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (ramWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected write", {ramAddr, ramData}, 32'h0);
        end else begin
          wr_t e;
          e = expQ.pop_front();
          check(ramAddr == e.a, "R6 write address", ramAddr, e.a);
          check(ramData == e.d, "R5 write data", ramData, e.d);
        end
      end
      if (extRdEn) begin
        if (inRun && extAddr == runAddr) begin
          runLen++;
        end else begin
          if (inRun) begin
            check(runLen == 2, "R3 strobe length", runLen, 2);
            check(extAddr == runAddr + 1, "R2 address step", extAddr, runAddr + 1);
          end else begin
            check(extAddr == '0, "R2 first address", extAddr, 0);
          end
          inRun = 1;
          runAddr = extAddr;
          runLen = 1;
        end
      end else if (inRun) begin
        check(runLen == 2, "R3 strobe length", runLen, 2);
        inRun = 0;
      end
    end
  end

  // Driver: writes the image, queues expected writes, runs one copy
  task automatic runLoad(input logic [15:0] dst, input int n, input logic [15:0] seed, input bit noise);
    int cnt;
    int expCnt;
    logic [15:0] w;
    mem[0] = dst[15:8]; mem[1] = dst[7:0];
    mem[2] = 8'(n >> 8); mem[3] = 8'(n);
    for (int i = 0; i < n; i++) begin
      w = seed ^ 16'(i * 16'h1357);
      mem[4 + 2*i] = w[15:8];
      mem[5 + 2*i] = w[7:0];
      expQ.push_back('{a: 16'(dst + 16'(i)), d: w});
    end
    @(negedge clk);
    start = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      start = (noise && (cnt == 5 || cnt == 11)) ? 1'b1 : 1'b0;
    end while (!done && cnt < 2000);
    start = 1'b0;
    expCnt = (n == 0) ? 9 : 10 + 4*n;
    if (n == 0) check(cnt == expCnt, "R7 done timing", cnt, expCnt);
    else if (noise) check(cnt == expCnt, "R9 timing with ignored start", cnt, expCnt);
    else check(cnt == expCnt, "R8 done timing", cnt, expCnt);
    check(jumpAddr == dst, "R4 jump address", jumpAddr, dst);
    check(expQ.size() == 0, "R6 all writes seen", expQ.size(), 0);
    expQ.delete();
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done held", done, 1);
    check(jumpAddr == dst, "R8 jump held", jumpAddr, dst);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done at reset", done, 0);
    check(extRdEn == 1'b0, "R1 strobe at reset", extRdEn, 0);
    check(ramWe == 1'b0, "R1 write at reset", ramWe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && extRdEn == 1'b0, "R1 idle after reset", {done, extRdEn}, 0);

    runLoad(16'h0100, 3, 16'hA55A, 1'b0);  // R4 R5 R6 R8
    runLoad(16'h2222, 0, 16'h0000, 1'b0);  // R7, restart from done R10
    runLoad(16'hFFFF, 2, 16'h1234, 1'b0);  // R6 wrap
    runLoad(16'h0040, 4, 16'hC3E1, 1'b1);  // R9 start pulses mid-copy
    runLoad(16'h8001, 1, 16'h00FF, 1'b0);  // R10 another fresh copy

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule